// File: doc/BRIEF.md
# Processor Mode-Bit Control Unit

This block keeps a handful of processor mode and status bits and updates them from single-cycle command strobes that the instruction decoder and the interrupt sequencer raise. It owns the stack pointer together with a flag that records whether the last align operation actually moved it. With that flag, a later unalign undoes exactly that adjustment and nothing more.

It also holds a vector-map bit and turns it into the base address of the interrupt vector table. A page-zero addressing-mode bit is compared with an external addressing-mode input, and an illegal-instruction trap is pulsed when both are 1. A loop-status flag is handed to the status save path and cleared on interrupt entry, and it is left alone on interrupt return. The block does no instruction decode and no stack memory writes.

Top module: `mode_bits_unit`

## Requirements
- R1: An align command while SP is odd adds one to SP (modulo 2^SP_W, so 0xFFFF becomes 0x0000) and sets the alignment flag on the next clock edge.
- R2: An align command while SP is even leaves SP unchanged and clears the alignment flag.
- R3: An unalign command while the alignment flag is 1 subtracts one from SP (modulo 2^SP_W, so 0x0000 becomes 0xFFFF) and clears the flag.
- R4: An unalign command while the alignment flag is 0 leaves SP and the flag unchanged.
- R5: After reset, SP equals SP_RESET, the alignment flag is 0, the vector-map bit is 1, the page-zero bit is 0, the loop flag is 0 and the trap output is 0.
- R6: The vector base output is VEC_W bits wide. It equals 0x3FFFC0 while the vector-map bit is 1 and 0x000000 while it is 0.
- R7: The vector-map bit and the page-zero bit each have a set strobe and a clear strobe. If both strobes for one bit arrive in the same cycle, the clear wins.
- R8: The trap output is high for exactly one cycle: the first cycle in which the page-zero bit and the addressing-mode input are both 1. It is combinational in that cycle.
- R9: On interrupt entry, the loop-save output carries the current loop flag during that same cycle, and the loop flag is 0 after the edge.
- R10: On interrupt return, the loop flag keeps its value whatever the restored loop bit input holds.
- R11: Interrupt entry blocks align, unalign, set and clear commands in its cycle. Align or unalign blocks set and clear commands in its cycle. Align wins over unalign.
- R12: The loop flag has its own set and clear strobes. The clear wins when both arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_cmd | input | 1 | Align-stack strobe |
| unalign_cmd | input | 1 | Unalign-stack strobe |
| vmap_set | input | 1 | Set vector-map bit |
| vmap_clr | input | 1 | Clear vector-map bit |
| pz_set | input | 1 | Set page-zero bit |
| pz_clr | input | 1 | Clear page-zero bit |
| loop_set | input | 1 | Set loop flag |
| loop_clr | input | 1 | Clear loop flag |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Interrupt return strobe |
| restored_loop | input | 1 | Loop bit of the restored status word (ignored) |
| amode_in | input | 1 | External addressing-mode bit |
| sp_o | output | SP_W | Stack pointer |
| align_flag_o | output | 1 | Alignment flag |
| vmap_o | output | 1 | Vector-map bit |
| page0_o | output | 1 | Page-zero mode bit (1 = direct, 0 = stack-relative) |
| loop_o | output | 1 | Loop flag |
| loop_save_o | output | 1 | Loop flag presented to the status save path on interrupt entry |
| vec_base_o | output | VEC_W | Interrupt vector table base |
| trap_o | output | 1 | Illegal-instruction trap pulse |

## Verification
The bench sets SP_RESET to 0xFFFF and keeps SP_W at 16 and VEC_W at 22. With that reset value, the first align command wraps SP to 0x0000 with the flag set, and the following unalign wraps it back to 0xFFFF. Both modulo corners are therefore reached without a long walk. The 22-bit vector width gives the exact 0x3FFFC0 and 0x000000 base values to compare against.

// File: rtl/mode_bits_pkg.sv
package mode_bits_pkg;

    typedef struct packed {
        logic align;
        logic vmap;
        logic page0;
        logic loop;
        logic illegal;
    } mode_flags_t;

    localparam mode_flags_t FLAGS_AT_RESET = '{align: 1'b0, vmap: 1'b1, page0: 1'b0,
                                              loop: 1'b0, illegal: 1'b0};

endpackage

// File: rtl/sp_align_next.sv
module sp_align_next #(
    parameter int SP_W = 16
) (
    input  logic [SP_W-1:0] sp_q,
    input  logic            align_q,
    input  logic            do_align,
    input  logic            do_unalign,
    output logic [SP_W-1:0] sp_d,
    output logic            align_d
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    always_comb begin
        sp_d    = sp_q;
        align_d = align_q;
        if (do_align) begin
            if (sp_q[0]) begin
                sp_d    = sp_q + ONE;
                align_d = 1'b1;
            end else begin
                align_d = 1'b0;
            end
        end else if (do_unalign && align_q) begin
            sp_d    = sp_q - ONE;
            align_d = 1'b0;
        end
    end
endmodule

// File: rtl/flag_next.sv
module flag_next (
    input  logic cur_q,
    input  logic en,
    input  logic set_cmd,
    input  logic clr_cmd,
    output logic nxt_d
);
    always_comb begin
        nxt_d = cur_q;
        if (en && clr_cmd)      nxt_d = 1'b0;
        else if (en && set_cmd) nxt_d = 1'b1;
    end
endmodule

// File: rtl/trap_edge.sv
module trap_edge (
    input  logic page0_q,
    input  logic amode_in,
    input  logic illegal_q,
    output logic illegal_d,
    output logic trap_pulse
);
    always_comb begin
        illegal_d  = page0_q & amode_in;
        trap_pulse = illegal_d & ~illegal_q;
    end
endmodule

// File: rtl/mode_bits_unit.sv
module mode_bits_unit
    import mode_bits_pkg::*;
#(
    parameter int              SP_W           = 16,
    parameter logic [SP_W-1:0] SP_RESET       = 16'h0400,
    parameter int              VEC_W          = 22,
    parameter int              VEC_TABLE_BITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_cmd,
    input  logic             unalign_cmd,
    input  logic             vmap_set,
    input  logic             vmap_clr,
    input  logic             pz_set,
    input  logic             pz_clr,
    input  logic             loop_set,
    input  logic             loop_clr,
    input  logic             irq_enter,
    input  logic             irq_return,
    input  logic             restored_loop,
    input  logic             amode_in,
    output logic [SP_W-1:0]  sp_o,
    output logic             align_flag_o,
    output logic             vmap_o,
    output logic             page0_o,
    output logic             loop_o,
    output logic             loop_save_o,
    output logic [VEC_W-1:0] vec_base_o,
    output logic             trap_o
);
    localparam logic [VEC_W-1:0] VEC_LOW_MASK = VEC_W'((1 << VEC_TABLE_BITS) - 1);
    localparam logic [VEC_W-1:0] VEC_HIGH     = ~VEC_LOW_MASK;

    mode_flags_t     flags_d, flags_q;
    logic [SP_W-1:0] sp_d, sp_q;

    logic en_stack, en_flags, do_align, do_unalign;
    logic align_nx, vmap_nx, page0_nx, loop_nx, illegal_nx, trap_w;
    logic [SP_W-1:0] sp_nx;

    assign en_stack   = ~irq_enter;
    assign do_align   = en_stack & align_cmd;
    assign do_unalign = en_stack & unalign_cmd & ~align_cmd;
    assign en_flags   = ~irq_enter & ~align_cmd & ~unalign_cmd;

    sp_align_next #(.SP_W(SP_W)) u_sp (
        .sp_q(sp_q), .align_q(flags_q.align), .do_align(do_align),
        .do_unalign(do_unalign), .sp_d(sp_nx), .align_d(align_nx)
    );

    flag_next u_vmap (.cur_q(flags_q.vmap), .en(en_flags), .set_cmd(vmap_set),
                      .clr_cmd(vmap_clr), .nxt_d(vmap_nx));
    flag_next u_page0 (.cur_q(flags_q.page0), .en(en_flags), .set_cmd(pz_set),
                       .clr_cmd(pz_clr), .nxt_d(page0_nx));
    flag_next u_loop (.cur_q(flags_q.loop), .en(en_flags), .set_cmd(loop_set),
                      .clr_cmd(loop_clr), .nxt_d(loop_nx));

    trap_edge u_trap (.page0_q(flags_q.page0), .amode_in(amode_in),
                      .illegal_q(flags_q.illegal), .illegal_d(illegal_nx),
                      .trap_pulse(trap_w));

    always_comb begin
        sp_d            = sp_nx;
        flags_d         = flags_q;
        flags_d.align   = align_nx;
        flags_d.vmap    = vmap_nx;
        flags_d.page0   = page0_nx;
        flags_d.loop    = irq_enter ? 1'b0 : loop_nx;
        flags_d.illegal = illegal_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q    <= SP_RESET;
            flags_q <= FLAGS_AT_RESET;
        end else begin
            sp_q    <= sp_d;
            flags_q <= flags_d;
        end
    end

    assign sp_o         = sp_q;
    assign align_flag_o = flags_q.align;
    assign vmap_o       = flags_q.vmap;
    assign page0_o      = flags_q.page0;
    assign loop_o       = flags_q.loop;
    assign loop_save_o  = irq_enter & flags_q.loop;
    assign vec_base_o   = flags_q.vmap ? VEC_HIGH : '0;
    assign trap_o       = trap_w;

    assert_align_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (align_cmd && !irq_enter && sp_o[0]) |=> (sp_o == $past(sp_o) + 1'b1) && align_flag_o);
    assert_align_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (align_cmd && !irq_enter && !sp_o[0]) |=> $stable(sp_o) && !align_flag_o);
    assert_unalign_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unalign_cmd && !align_cmd && !irq_enter && align_flag_o)
        |=> (sp_o == $past(sp_o) - 1'b1) && !align_flag_o);
    assert_unalign_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unalign_cmd && !align_cmd && !irq_enter && !align_flag_o) |=> $stable(sp_o));
    assert_vmap_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vmap_clr && !irq_enter && !align_cmd && !unalign_cmd) |=> !vmap_o);
    assert_trap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (page0_o && amode_in));
    assert_trap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);
    assert_irq_clears_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> !loop_o);
    assert_return_keeps_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && (restored_loop != loop_o) && !irq_enter && !loop_set && !loop_clr)
        |=> $stable(loop_o));
    assert_irq_blocks_stack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> $stable(sp_o) && $stable(vmap_o) && $stable(page0_o));
endmodule

// File: tb/mode_bits_unit_tb.sv
module mode_bits_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic align_cmd = 0, unalign_cmd = 0, vmap_set = 0, vmap_clr = 0;
    logic pz_set = 0, pz_clr = 0, loop_set = 0, loop_clr = 0;
    logic irq_enter = 0, irq_return = 0, restored_loop = 0, amode_in = 0;
    logic [15:0] sp_o;
    logic [21:0] vec_base_o;
    logic align_flag_o, vmap_o, page0_o, loop_o, loop_save_o, trap_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mode_bits_unit #(.SP_W(16), .SP_RESET(16'hFFFF), .VEC_W(22), .VEC_TABLE_BITS(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .align_cmd(align_cmd), .unalign_cmd(unalign_cmd),
        .vmap_set(vmap_set), .vmap_clr(vmap_clr), .pz_set(pz_set), .pz_clr(pz_clr),
        .loop_set(loop_set), .loop_clr(loop_clr), .irq_enter(irq_enter),
        .irq_return(irq_return), .restored_loop(restored_loop), .amode_in(amode_in),
        .sp_o(sp_o), .align_flag_o(align_flag_o), .vmap_o(vmap_o), .page0_o(page0_o),
        .loop_o(loop_o), .loop_save_o(loop_save_o), .vec_base_o(vec_base_o), .trap_o(trap_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic clear_cmds();
        align_cmd = 0; unalign_cmd = 0; vmap_set = 0; vmap_clr = 0;
        pz_set = 0; pz_clr = 0; loop_set = 0; loop_clr = 0;
        irq_enter = 0; irq_return = 0;
    endtask

    // Commands are already driven; let one edge pass and release them.
    task automatic step();
        @(negedge clk);
        clear_cmds();
        #1;
    endtask

    task automatic t_reset();
        clear_cmds(); amode_in = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R5 sp", 32'(sp_o), 32'hFFFF);
        check("R5 align flag", 32'(align_flag_o), 0);
        check("R5 vmap", 32'(vmap_o), 1);
        check("R5 page0", 32'(page0_o), 0);
        check("R5 loop", 32'(loop_o), 0);
        check("R5 trap", 32'(trap_o), 0);
        check("R6 base high", 32'(vec_base_o), 32'h3FFFC0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic t_stack();
        align_cmd = 1; step();
        check("R1 wrap sp", 32'(sp_o), 32'h0000);
        check("R1 flag set", 32'(align_flag_o), 1);
        unalign_cmd = 1; step();
        check("R3 wrap sp", 32'(sp_o), 32'hFFFF);
        check("R3 flag clr", 32'(align_flag_o), 0);
        unalign_cmd = 1; step();
        check("R4 sp held", 32'(sp_o), 32'hFFFF);
        align_cmd = 1; step();
        align_cmd = 1; step();
        check("R2 even sp", 32'(sp_o), 32'h0000);
        check("R2 flag clr", 32'(align_flag_o), 0);
        unalign_cmd = 1; step();
        check("R4 sp held even", 32'(sp_o), 32'h0000);
        check("R4 flag held", 32'(align_flag_o), 0);
    endtask

    task automatic t_vmap();
        vmap_clr = 1; step();
        check("R7 vmap clr", 32'(vmap_o), 0);
        check("R6 base low", 32'(vec_base_o), 0);
        vmap_set = 1; step();
        check("R7 vmap set", 32'(vmap_o), 1);
        vmap_set = 1; vmap_clr = 1; step();
        check("R7 clear wins", 32'(vmap_o), 0);
        vmap_set = 1; step();
        check("R6 base back", 32'(vec_base_o), 32'h3FFFC0);
    endtask

    task automatic t_trap();
        pz_set = 1; step();
        check("R7 page0 set", 32'(page0_o), 1);
        check("R8 no trap amode0", 32'(trap_o), 0);
        @(negedge clk); amode_in = 1; #1;
        check("R8 trap first cycle", 32'(trap_o), 1);
        @(negedge clk); #1;
        check("R8 trap one cycle", 32'(trap_o), 0);
        @(negedge clk); amode_in = 0; @(negedge clk); amode_in = 1; #1;
        check("R8 trap again", 32'(trap_o), 1);
        pz_clr = 1; pz_set = 1; step();
        check("R7 page0 clear wins", 32'(page0_o), 0);
        check("R8 no trap page0 0", 32'(trap_o), 0);
        amode_in = 0;
    endtask

    task automatic t_loop();
        loop_set = 1; step();
        check("R12 loop set", 32'(loop_o), 1);
        @(negedge clk); irq_enter = 1; #1;
        check("R9 save path", 32'(loop_save_o), 1);
        step();
        check("R9 loop cleared", 32'(loop_o), 0);
        loop_set = 1; step();
        irq_return = 1; restored_loop = 0; step();
        check("R10 kept 1", 32'(loop_o), 1);
        loop_set = 1; loop_clr = 1; step();
        check("R12 clear wins", 32'(loop_o), 0);
        irq_return = 1; restored_loop = 1; step();
        check("R10 kept 0", 32'(loop_o), 0);
        restored_loop = 0;
    endtask

    task automatic t_priority();
        t_reset();
        align_cmd = 1; unalign_cmd = 1; step();
        check("R11 align over unalign", 32'(sp_o), 32'h0000);
        irq_enter = 1; unalign_cmd = 1; vmap_clr = 1; loop_set = 1; step();
        check("R11 irq blocks unalign", 32'(sp_o), 32'h0000);
        check("R11 irq blocks vmap", 32'(vmap_o), 1);
        check("R11 irq blocks loop set", 32'(loop_o), 0);
        unalign_cmd = 1; vmap_clr = 1; step();
        check("R11 unalign runs", 32'(sp_o), 32'hFFFF);
        check("R11 stack blocks vmap", 32'(vmap_o), 1);
    endtask

    initial begin
        t_reset();
        t_stack();
        t_vmap();
        t_trap();
        t_loop();
        t_priority();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule